// File: doc/BRIEF.md
# Display Command Stream Register Decoder

This block sits behind a byte-wide transport and turns a stream of display-controller commands into register state. One byte enters per cycle whenever `inValid` is high. The input is always ready. Every command opens with the escape byte 0xAF and an opcode. The decoder handles two opcodes. One writes a single 8-bit register. The other describes a pixel copy, and the decoder reports it to a downstream engine as a one-cycle request.

Register writes land in a shadow file. A write to the lock register at address 0xFF freezes the visible registers. A later unlock write to the same address moves the whole shadow file into the active file in one edge, so a complete mode change becomes visible at once. The active file drives the output ports: pixel depth select, two 24-bit framebuffer bases, twelve 16-bit timing words, a pixel-clock word and a blanking mode.

Top module: `bulk_cmd_decoder`

## Requirements
- R1: After reset every active register output is zero, `copyReq` is low, the registers are unlocked and `inReady` is high.
- R2: The byte sequence 0xAF, 0x20, address, value writes value to that register. While unlocked, the value is visible on the outputs in the cycle after the value byte is accepted. Addresses at or above REG_COUNT, other than 0xFF, are ignored.
- R3: Register 0x00 drives `colorDepth`. Registers 0x20, 0x21 and 0x22 form `base16` with the most significant byte at 0x20. Registers 0x26, 0x27 and 0x28 form `base8` in the same order.
- R4: Timing word k (k = 0..11) takes its high byte from register 0x01+2k and its low byte from 0x02+2k. It appears at `timingRegs[16k+15:16k]`. Register 0x1F drives `blankMode`.
- R5: `pixClk` is the exception to the byte order: its low byte is register 0x1B and its high byte is register 0x1C.
- R6: Writing 0x00 to register 0xFF locks the active file. Later register writes do not change any output until unlock.
- R7: Writing 0xFF to register 0xFF unlocks. In the same edge, every shadow register is copied to the active file.
- R8: The sequence 0xAF, 0x6A and seven payload bytes is a copy command. The payload is the source address (three bytes, MSB first), then the pixel count, then the destination address (three bytes, MSB first). `copyReq` is high for exactly one cycle, starting in the cycle after the last byte. `copySrc`, `copyCount` and `copyDst` carry the fields and hold them until the next copy.
- R9: An opcode other than 0x20, 0x6A or 0xAF is discarded. Bytes are then ignored until the next 0xAF.
- R10: A 0xAF in the opcode position is taken as a fresh prefix. A lone trailing 0xAF therefore changes no output, and the command that follows it decodes normally.
- R11: Cycles with `inValid` low are ignored, even in the middle of a command, and the command completes when its remaining bytes arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inData | input | 8 | Stream byte |
| inValid | input | 1 | Byte present this cycle |
| inReady | output | 1 | Always high out of the decoder |
| colorDepth | output | 8 | Active pixel depth select (0 = 16 bpp) |
| base16 | output | 24 | Active 16 bpp plane base |
| base8 | output | 24 | Active 8 bpp plane base |
| timingRegs | output | NUM_TIMING*16 | Active timing words, word k at bits 16k+15:16k |
| pixClk | output | 16 | Active pixel-clock word |
| blankMode | output | 8 | Active blanking mode |
| copyReq | output | 1 | One-cycle copy request |
| copySrc | output | 24 | Copy source address |
| copyCount | output | 8 | Copy pixel count |
| copyDst | output | 24 | Copy destination address |

## Verification
Two functions can share a cycle. While the copy request is still pulsing, the parser can already be accepting the prefix of the next command. The bench provokes this by sending a copy and a register write back to back with no idle cycle between them. It judges the result by the following: exactly one request pulse is counted, the copy fields are correct, and the following register write still lands. The lock-then-unlock path is also judged on the edge itself: every register written while locked must appear together in the first sample after the unlock byte.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam logic [7:0] PREFIX     = 8'hAF;
  localparam logic [7:0] OP_WR      = 8'h20;
  localparam logic [7:0] OP_COPY    = 8'h6A;
  localparam logic [7:0] LOCK_ADDR  = 8'hFF;
  localparam logic [7:0] LOCK_VAL   = 8'h00;
  localparam logic [7:0] UNLOCK_VAL = 8'hFF;

  localparam int CP_ADDR_BYTES = 3;
  localparam int CP_ADDR_W     = CP_ADDR_BYTES * 8;
  localparam int COPY_PAYLOAD  = 2 * CP_ADDR_BYTES + 1;

  localparam int DEPTH_REG   = 8'h00;
  localparam int BASE16_REG  = 8'h20;
  localparam int BASE8_REG   = 8'h26;
  localparam int TIMING_REG  = 8'h01;
  localparam int PIXCLK_REG  = 8'h1B;
  localparam int BLANK_REG   = 8'h1F;

  typedef struct packed {
    logic       regWr;
    logic [7:0] regAddr;
    logic       copyByte;
    logic       copyLast;
    logic [7:0] dat;
  } ctlStb_t;
endpackage

// File: rtl/bcd_parser.sv
module bcd_parser
  import bcd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] inData,
  input  logic       inValid,
  output ctlStb_t    ctl
);
  localparam int CNT_W = $clog2(COPY_PAYLOAD);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(COPY_PAYLOAD - 1);

  typedef enum logic [2:0] {S_HUNT, S_OPC, S_ADDR, S_VAL, S_COPY} pstate_t;

  pstate_t          state;
  logic [7:0]       addrQ;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_HUNT;
      addrQ <= '0;
      cnt   <= '0;
    end else if (inValid) begin
      case (state)
        S_HUNT: if (inData == PREFIX) state <= S_OPC;
        S_OPC: begin
          if (inData == OP_WR) begin
            state <= S_ADDR;
          end else if (inData == OP_COPY) begin
            state <= S_COPY;
            cnt   <= '0;
          end else if (inData != PREFIX) begin
            state <= S_HUNT;
          end
        end
        S_ADDR: begin
          addrQ <= inData;
          state <= S_VAL;
        end
        S_VAL: state <= S_HUNT;
        S_COPY: begin
          if (cnt == CNT_LAST) state <= S_HUNT;
          else cnt <= cnt + 1'b1;
        end
        default: state <= S_HUNT;
      endcase
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.regAddr  = addrQ;
    ctl.dat      = inData;
    ctl.regWr    = inValid && (state == S_VAL);
    ctl.copyByte = inValid && (state == S_COPY);
    ctl.copyLast = ctl.copyByte && (cnt == CNT_LAST);
  end
endmodule

// File: rtl/bcd_regs.sv
module bcd_regs
  import bcd_pkg::*;
#(
  parameter int REG_COUNT = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStb_t              ctl,
  output logic [7:0]           act [REG_COUNT],
  output logic                 locked,
  output logic                 copyReq,
  output logic [CP_ADDR_W-1:0] copySrc,
  output logic [7:0]           copyCount,
  output logic [CP_ADDR_W-1:0] copyDst
);
  localparam int IDX_W = $clog2(REG_COUNT);
  localparam logic [8:0] REG_LIMIT = 9'(REG_COUNT);
  localparam int SH_W = (COPY_PAYLOAD - 1) * 8;

  logic [7:0]      shadow [REG_COUNT];
  logic [SH_W-1:0] copySh;
  logic            inFile;
  logic [IDX_W-1:0] idx;

  assign inFile = ({1'b0, ctl.regAddr} < REG_LIMIT);
  assign idx    = ctl.regAddr[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      locked <= 1'b0;
      for (int i = 0; i < REG_COUNT; i++) begin
        shadow[i] <= '0;
        act[i]    <= '0;
      end
    end else if (ctl.regWr) begin
      if (ctl.regAddr == LOCK_ADDR) begin
        if (ctl.dat == LOCK_VAL) begin
          locked <= 1'b1;
        end else if (ctl.dat == UNLOCK_VAL) begin
          locked <= 1'b0;
          for (int i = 0; i < REG_COUNT; i++) act[i] <= shadow[i];
        end
      end else if (inFile) begin
        shadow[idx] <= ctl.dat;
        if (!locked) act[idx] <= ctl.dat;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      copySh    <= '0;
      copyReq   <= 1'b0;
      copySrc   <= '0;
      copyCount <= '0;
      copyDst   <= '0;
    end else begin
      copyReq <= ctl.copyLast;
      if (ctl.copyByte) copySh <= {copySh[SH_W-9:0], ctl.dat};
      if (ctl.copyLast) begin
        copySrc   <= copySh[SH_W-1 -: CP_ADDR_W];
        copyCount <= copySh[SH_W-CP_ADDR_W-1 -: 8];
        copyDst   <= {copySh[CP_ADDR_W-9:0], ctl.dat};
      end
    end
  end
endmodule

// File: rtl/bulk_cmd_decoder.sv
module bulk_cmd_decoder
  import bcd_pkg::*;
#(
  parameter int REG_COUNT  = 64,
  parameter int NUM_TIMING = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [7:0]              inData,
  input  logic                    inValid,
  output logic                    inReady,
  output logic [7:0]              colorDepth,
  output logic [23:0]             base16,
  output logic [23:0]             base8,
  output logic [NUM_TIMING*16-1:0] timingRegs,
  output logic [15:0]             pixClk,
  output logic [7:0]              blankMode,
  output logic                    copyReq,
  output logic [23:0]             copySrc,
  output logic [7:0]              copyCount,
  output logic [23:0]             copyDst
);
  ctlStb_t    ctl;
  logic [7:0] act [REG_COUNT];
  logic       locked;

  assign inReady = 1'b1;

  bcd_parser parser_i (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid), .ctl(ctl)
  );

  bcd_regs #(.REG_COUNT(REG_COUNT)) regs_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .act(act), .locked(locked),
    .copyReq(copyReq), .copySrc(copySrc), .copyCount(copyCount), .copyDst(copyDst)
  );

  assign colorDepth = act[DEPTH_REG];
  assign base16     = {act[BASE16_REG], act[BASE16_REG+1], act[BASE16_REG+2]};
  assign base8      = {act[BASE8_REG], act[BASE8_REG+1], act[BASE8_REG+2]};
  assign pixClk     = {act[PIXCLK_REG+1], act[PIXCLK_REG]};
  assign blankMode  = act[BLANK_REG];

  for (genvar k = 0; k < NUM_TIMING; k++) begin : g_timing
    assign timingRegs[k*16 +: 16] = {act[TIMING_REG+2*k], act[TIMING_REG+2*k+1]};
  end
endmodule

// File: rtl/bulk_cmd_decoder_chk.sv
module bulk_cmd_decoder_chk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        locked,
  input logic [7:0]  colorDepth,
  input logic [23:0] base16,
  input logic [7:0]  blankMode,
  input logic        copyReq,
  input logic [23:0] copySrc,
  input logic [7:0]  copyCount,
  input logic [23:0] copyDst
);
  // R8
  copy_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    copyReq |=> !copyReq);

  // R8
  copy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    copyReq |=> ($stable(copySrc) && $stable(copyCount) && $stable(copyDst)));

  // R11
  copy_needs_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    copyReq |-> $past(inValid));

  // R6
  lock_depth_chk: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> (!locked || $stable(colorDepth)));

  // R6
  lock_base_chk: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> (!locked || $stable(base16)));

  // R6
  lock_blank_chk: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> (!locked || $stable(blankMode)));
endmodule

bind bulk_cmd_decoder bulk_cmd_decoder_chk chk_i (
  .clk(clk), .rstN(rstN), .inValid(inValid), .locked(regs_i.locked),
  .colorDepth(colorDepth), .base16(base16), .blankMode(blankMode),
  .copyReq(copyReq), .copySrc(copySrc), .copyCount(copyCount), .copyDst(copyDst)
);

// File: tb/bulk_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module bulk_cmd_decoder_tb_top;
  localparam int NUM_TIMING = 12;
  localparam int NVEC = 14;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] inData = '0;
  logic inValid = 1'b0;
  logic inReady;
  logic [7:0] colorDepth, blankMode, copyCount;
  logic [23:0] base16, base8, copySrc, copyDst;
  logic [NUM_TIMING*16-1:0] timingRegs;
  logic [15:0] pixClk;
  logic copyReq;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bulk_cmd_decoder dut_i (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid), .inReady(inReady),
    .colorDepth(colorDepth), .base16(base16), .base8(base8), .timingRegs(timingRegs),
    .pixClk(pixClk), .blankMode(blankMode), .copyReq(copyReq), .copySrc(copySrc),
    .copyCount(copyCount), .copyDst(copyDst)
  );

  // {addr, value, select, timing index, expected}
  // select: 0 depth, 1 base16, 2 base8, 3 timing, 4 blank, 5 pixel clock
  localparam logic [47:0] VEC [NVEC] = '{
    {8'h00, 8'h01, 4'd0, 4'd0,  24'h000001},
    {8'h20, 8'h12, 4'd1, 4'd0,  24'h120000},
    {8'h21, 8'h34, 4'd1, 4'd0,  24'h123400},
    {8'h22, 8'h56, 4'd1, 4'd0,  24'h123456},
    {8'h26, 8'hAB, 4'd2, 4'd0,  24'hAB0000},
    {8'h27, 8'hCD, 4'd2, 4'd0,  24'hABCD00},
    {8'h28, 8'hEF, 4'd2, 4'd0,  24'hABCDEF},
    {8'h01, 8'h0A, 4'd3, 4'd0,  24'h000A00},
    {8'h02, 8'h0B, 4'd3, 4'd0,  24'h000A0B},
    {8'h17, 8'h03, 4'd3, 4'd11, 24'h000300},
    {8'h18, 8'h20, 4'd3, 4'd11, 24'h000320},
    {8'h1B, 8'h40, 4'd5, 4'd0,  24'h000040},
    {8'h1C, 8'h1F, 4'd5, 4'd0,  24'h001F40},
    {8'h1F, 8'h03, 4'd4, 4'd0,  24'h000003}
  };

  always @(negedge clk) if (rstN && copyReq) pulses++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sendRaw(input logic [7:0] b);
    @(negedge clk);
    inValid = 1'b1;
    inData  = b;
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [7:0] v);
    sendRaw(8'hAF); sendRaw(8'h20); sendRaw(a); sendRaw(v);
    idle();
  endtask

  function automatic logic [31:0] pick(input logic [3:0] sel, input int k);
    case (sel)
      4'd0: return {24'd0, colorDepth};
      4'd1: return {8'd0, base16};
      4'd2: return {8'd0, base8};
      4'd3: return {16'd0, timingRegs[k*16 +: 16]};
      4'd4: return {24'd0, blankMode};
      default: return {16'd0, pixClk};
    endcase
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    int p0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 depth", {24'd0, colorDepth}, 0);
    check("R1 bases", {base16 | base8, 8'd0}, 0);
    check("R1 timing/pixclk/blank", {8'd0, |timingRegs, pixClk, blankMode}, 0);
    check("R1 copyReq/inReady", {30'd0, copyReq, inReady}, 1);

    // R2 R3 R4 R5 table of register writes while unlocked
    for (int i = 0; i < NVEC; i++) begin
      regWrite(VEC[i][47:40], VEC[i][39:32]);
      check($sformatf("R2 vector %0d", i), pick(VEC[i][31:28], int'(VEC[i][27:24])),
            {8'd0, VEC[i][23:0]});
    end

    // R6 lock: writes held back from outputs
    regWrite(8'hFF, 8'h00);
    regWrite(8'h00, 8'h07);
    check("R6 depth held", {24'd0, colorDepth}, 32'h01);
    regWrite(8'h20, 8'h99);
    check("R6 base16 held", {8'd0, base16}, 32'h123456);
    // R7 unlock copies all shadow registers at once
    regWrite(8'hFF, 8'hFF);
    check("R7 depth after unlock", {24'd0, colorDepth}, 32'h07);
    check("R7 base16 after unlock", {8'd0, base16}, 32'h993456);

    // R9 unknown opcode discarded, following bytes not decoded
    sendRaw(8'hAF); sendRaw(8'h55); sendRaw(8'h20); sendRaw(8'h00); sendRaw(8'h09);
    idle();
    check("R9 unknown opcode", {24'd0, colorDepth}, 32'h07);

    // R10 double prefix restarts
    sendRaw(8'hAF); sendRaw(8'hAF); sendRaw(8'h20); sendRaw(8'h00); sendRaw(8'h0A);
    idle();
    check("R10 double prefix", {24'd0, colorDepth}, 32'h0A);

    // R10 lone trailing prefix has no effect
    sendRaw(8'hAF);
    idle();
    repeat (3) @(negedge clk);
    check("R10 pad no change", {15'd0, copyReq, colorDepth, blankMode}, 32'h0A03);
    regWrite(8'h1F, 8'h05);
    check("R10 next command after pad", {24'd0, blankMode}, 32'h05);

    // R11 gaps inside a command
    sendRaw(8'hAF); idle(); sendRaw(8'h20); idle(); idle(); sendRaw(8'h00); idle();
    check("R11 mid-command no write", {24'd0, colorDepth}, 32'h0A);
    sendRaw(8'h0C); idle();
    check("R11 gapped write", {24'd0, colorDepth}, 32'h0C);

    // R8 copy with gaps
    sendRaw(8'hAF); sendRaw(8'h6A); sendRaw(8'h01); idle(); sendRaw(8'h02);
    sendRaw(8'h03); sendRaw(8'h10); idle(); sendRaw(8'h04); sendRaw(8'h05);
    sendRaw(8'h06); idle();
    check("R8 strobe high", {31'd0, copyReq}, 1);
    check("R8 src", {8'd0, copySrc}, 32'h010203);
    check("R8 count", {24'd0, copyCount}, 32'h10);
    check("R8 dst", {8'd0, copyDst}, 32'h040506);
    @(negedge clk);
    check("R8 strobe one cycle", {31'd0, copyReq}, 0);
    check("R8 fields held", {8'd0, copySrc ^ copyDst}, 32'h010203 ^ 32'h040506);

    // R8 back to back: copy then register write with no idle cycle
    p0 = pulses;
    sendRaw(8'hAF); sendRaw(8'h6A);
    sendRaw(8'h11); sendRaw(8'h22); sendRaw(8'h33); sendRaw(8'h44);
    sendRaw(8'h55); sendRaw(8'h66); sendRaw(8'h77);
    sendRaw(8'hAF); sendRaw(8'h20); sendRaw(8'h00); sendRaw(8'h0D);
    idle();
    repeat (2) @(negedge clk);
    check("R8 one pulse back to back", pulses - p0, 1);
    check("R8 src/count b2b", {copySrc, copyCount}, 32'h11223344);
    check("R8 dst b2b", {8'd0, copyDst}, 32'h556677);
    check("R2 write after copy", {24'd0, colorDepth}, 32'h0D);

    done = 1;
    summary();
    $finish;
  end
endmodule